// File: doc/BRIEF.md
# Tachometer Capture Counter

This block measures the period of a tachometer signal. An internal counter advances by one on every clock while it is running. When a capture fires, the current count is copied into a capture register and a one-cycle event pulse is raised. A capture can come from a chosen edge of the tachometer input or from a software command, depending on the source select. Software then reads the captured value. The difference between two successive captures, or a single capture when the counter is cleared on each capture, gives the input period in clock cycles.

The counter has two modes. In continuous mode it keeps running through every capture and every wrap. In one-shot mode it disarms itself on the first capture or the first wrap, so a single measurement can be taken without any software timing. A sticky overflow flag records a wrap from all ones to zero. The tachometer input is asynchronous and goes through a synchronizer before edge detection.

Top module: `tach_capture`

## Requirements
- R1: While `run_en` is 0 the counter holds its value. A write with `run_wr`=1 loads `run_wdata` into `run_en`, and counting continues from the held value.
- R2: A `clr_cmd` pulse sets the counter to 0 at the next clock edge. After that the counter advances by exactly one on each edge while `run_en` is 1.
- R3: When `clr_on_cap` is 1, a capture also sets the counter to 0 in the same edge. When it is 0, the counter keeps counting through captures.
- R4: With `src_sw`=0, only tachometer edges capture and `sw_cap` is ignored. With `src_sw`=1, only `sw_cap` pulses capture and input edges are ignored.
- R5: `edge_sel` encoding: 2'b00 means no capture, 2'b01 means falling edge, 2'b10 means rising edge, 2'b11 means both edges.
- R6: `tach_in` passes through a two-flop synchronizer. Each input edge produces exactly one capture, so two selected edges P clocks apart give captures that differ by P.
- R7: With `one_shot`=0, the counter wraps from all ones to 0 and `run_en` stays 1.
- R8: With `one_shot`=1, a capture or a wrap clears `run_en` in hardware. While `run_en` is 0, no capture happens.
- R9: A wrap sets the sticky `ovf_flag`, which stays set until an `ovf_clr` pulse. If a wrap and `ovf_clr` occur in the same cycle, the set wins.
- R10: If `clr_cmd` and a capture happen in the same cycle, `cap_val` receives the count held before the clear.
- R11: A capture loads `cap_val` and raises `cap_evt` for exactly one cycle, both at the clock edge that samples the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 1 | Asynchronous tachometer signal |
| run_wr | input | 1 | Write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| clr_cmd | input | 1 | One-cycle counter clear command |
| clr_on_cap | input | 1 | Clear the counter on each capture |
| src_sw | input | 1 | Capture source: 0 input edges, 1 software |
| sw_cap | input | 1 | One-cycle software capture command |
| one_shot | input | 1 | 0 continuous, 1 one-shot |
| edge_sel | input | 2 | Edge sensitivity, see R5 |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| cap_val | output | CNT_W | Captured count |
| cap_evt | output | 1 | One-cycle capture pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| run_en | output | 1 | Run bit, cleared by hardware in one-shot mode |

## Verification
The hardest case to reach from the ports is a one-shot wrap. The counter must be started from zero and left running for exactly 2^CNT_W clocks with no capture, and only then do the wrap, the flag set and the disarm all happen on one edge. The bench builds the block with an 8-bit counter and counts the clocks from a combined run-and-clear write. It checks the flag and the run bit one clock before the wrap and again on the wrap edge. A clear that coincides with a capture is reached by driving both one-cycle commands at the same falling edge.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;
  localparam logic [1:0] EDGE_RISE = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  // Selected-edge decision from the sensitivity code
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[1] & rise) | (sel[0] & fall);
  endfunction

  // Wrap occurs when a running counter sits at all ones and is not cleared
  function automatic logic will_wrap(input logic run, input logic clr, input logic all_ones);
    return run & ~clr & all_ones;
  endfunction
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], sig_in};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R6
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall); // R6
endmodule

// File: rtl/tach_counter.sv
module tach_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  import tach_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = will_wrap(run, clear, cnt_q == CNT_MAX);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !clear) |=> $stable(cnt_q)); // R1
  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/tach_capture.sv
module tach_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             clr_cmd,
  input  logic             clr_on_cap,
  input  logic             src_sw,
  input  logic             sw_cap,
  input  logic             one_shot,
  input  logic [1:0]       edge_sel,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt,
  output logic             ovf_flag,
  output logic             run_en
);
  import tach_pkg::*;

  logic             in_rise, in_fall;
  logic             hw_fire, sw_fire, cap_fire, cnt_clear, cnt_wrap;
  logic [CNT_W-1:0] cnt_now;
  logic             run_q, ovf_q, evt_q;
  logic [CNT_W-1:0] cap_q;

  tach_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(tach_in), .rise(in_rise), .fall(in_fall)
  );

  assign hw_fire   = ~src_sw & edge_hit(edge_sel, in_rise, in_fall);
  assign sw_fire   = src_sw & sw_cap;
  assign cap_fire  = run_q & (hw_fire | sw_fire);
  assign cnt_clear = clr_cmd | (cap_fire & clr_on_cap);

  tach_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clear(cnt_clear),
    .cnt(cnt_now), .wrap(cnt_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= cap_fire;
      if (cap_fire) cap_q <= cnt_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             run_q <= 1'b0;
    else if (run_wr)                        run_q <= run_wdata;
    else if (one_shot & (cap_fire | cnt_wrap)) run_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (cnt_wrap) ovf_q <= 1'b1;
    else if (ovf_clr)  ovf_q <= 1'b0;
  end

  assign cap_val  = cap_q;
  assign cap_evt  = evt_q;
  assign ovf_flag = ovf_q;
  assign run_en   = run_q;

  AST_CAP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |-> $past(run_q)); // R8
  AST_OS_DISARM: assert property (@(posedge clk) disable iff (!rst_n) (one_shot && (cap_fire || cnt_wrap) && !run_wr) |=> !run_q); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !ovf_clr) |=> ovf_q); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) cnt_wrap |=> ovf_q); // R9
  AST_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (cap_fire && src_sw) |-> sw_cap); // R4
  AST_PRE_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n) cap_fire |=> (cap_q == $past(cnt_now))); // R10
endmodule

// File: tb/tach_capture_test.sv
`timescale 1ns/1ps
module tach_capture_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach_in = 1'b0, run_wr = 1'b0, run_wdata = 1'b0, clr_cmd = 1'b0;
  logic clr_on_cap = 1'b0, src_sw = 1'b0, sw_cap = 1'b0, one_shot = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic ovf_clr = 1'b0;
  logic [W-1:0] cap_val;
  logic cap_evt, ovf_flag, run_en;

  int n_chk = 0, n_fail = 0;
  int evt_cnt = 0;
  int last_cap = 0, prev_cap = 0;

  always #2 clk = ~clk;

  tach_capture #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .run_wr(run_wr), .run_wdata(run_wdata),
    .clr_cmd(clr_cmd), .clr_on_cap(clr_on_cap), .src_sw(src_sw), .sw_cap(sw_cap),
    .one_shot(one_shot), .edge_sel(edge_sel), .ovf_clr(ovf_clr),
    .cap_val(cap_val), .cap_evt(cap_evt), .ovf_flag(ovf_flag), .run_en(run_en)
  );

  always @(posedge clk) begin
    #1;
    if (cap_evt) begin
      evt_cnt  = evt_cnt + 1;
      prev_cap = last_cap;
      last_cap = int'(cap_val);
    end
  end

  task automatic chk(input string rid, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rid, act, exp);
    end
  endtask

  task automatic start(input logic os, input logic cor, input logic src, input logic [1:0] es);
    @(negedge clk);
    one_shot = os; clr_on_cap = cor; src_sw = src; edge_sel = es;
    run_wr = 1'b1; run_wdata = 1'b1; clr_cmd = 1'b1;
    @(negedge clk);
    run_wr = 1'b0; clr_cmd = 1'b0;
  endtask

  task automatic pulse_sw;
    sw_cap = 1'b1;
    @(negedge clk);
    sw_cap = 1'b0;
  endtask

  task automatic write_run(input logic v);
    run_wr = 1'b1; run_wdata = v;
    @(negedge clk);
    run_wr = 1'b0;
  endtask

  task automatic t_sw_capture;
    start(1'b0, 1'b0, 1'b1, 2'b00);
    repeat (9) @(negedge clk);
    pulse_sw;
    chk("R2 count from zero", int'(cap_val), 9);
    chk("R11 evt high", int'(cap_evt), 1);
    @(negedge clk);
    chk("R11 evt one cycle", int'(cap_evt), 0);
    repeat (3) @(negedge clk);
    pulse_sw;
    chk("R3 no clear keeps counting", int'(cap_val), 14);
    tach_in = 1'b1;
    edge_sel = 2'b11;
    repeat (6) @(negedge clk);
    tach_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 edge ignored under sw source", int'(cap_val), 14);
    write_run(1'b0);
  endtask

  task automatic t_sw_ignored;
    start(1'b0, 1'b0, 1'b0, 2'b00);
    repeat (5) @(negedge clk);
    pulse_sw;
    chk("R4 sw pulse ignored evt", int'(cap_evt), 0);
    chk("R4 sw pulse ignored value", int'(cap_val), 14);
    write_run(1'b0);
  endtask

  task automatic t_stop_resume;
    start(1'b0, 1'b0, 1'b1, 2'b00);
    repeat (4) @(negedge clk);
    write_run(1'b0);
    repeat (10) @(negedge clk);
    chk("R1 run bit cleared", int'(run_en), 0);
    write_run(1'b1);
    repeat (3) @(negedge clk);
    pulse_sw;
    chk("R1 held then resumed", int'(cap_val), 8);
    write_run(1'b0);
  endtask

  task automatic t_clear_on_cap;
    start(1'b0, 1'b1, 1'b1, 2'b00);
    repeat (5) @(negedge clk);
    pulse_sw;
    chk("R3 first capture", int'(cap_val), 5);
    repeat (3) @(negedge clk);
    pulse_sw;
    chk("R3 cleared on capture", int'(cap_val), 3);
    write_run(1'b0);
  endtask

  task automatic t_clr_with_cap;
    start(1'b0, 1'b0, 1'b1, 2'b00);
    repeat (7) @(negedge clk);
    clr_cmd = 1'b1;
    pulse_sw;
    clr_cmd = 1'b0;
    chk("R10 pre-clear value", int'(cap_val), 7);
    repeat (2) @(negedge clk);
    pulse_sw;
    chk("R2 clear then count", int'(cap_val), 2);
    write_run(1'b0);
  endtask

  task automatic t_edges(input logic [1:0] es, input int exp_n, input int exp_diff, input string rid);
    int base;
    start(1'b0, 1'b0, 1'b0, es);
    base = evt_cnt;
    tach_in = 1'b1; repeat (20) @(negedge clk);
    tach_in = 1'b0; repeat (25) @(negedge clk);
    tach_in = 1'b1; repeat (10) @(negedge clk);
    tach_in = 1'b0; repeat (6) @(negedge clk);
    chk({rid, " event count"}, evt_cnt - base, exp_n);
    if (exp_n >= 2) chk({rid, " period"}, last_cap - prev_cap, exp_diff);
    write_run(1'b0);
  endtask

  task automatic t_oneshot_cap;
    int base;
    start(1'b1, 1'b0, 1'b1, 2'b00);
    repeat (6) @(negedge clk);
    pulse_sw;
    chk("R8 one-shot capture value", int'(cap_val), 6);
    chk("R8 one-shot disarm on capture", int'(run_en), 0);
    base = evt_cnt;
    @(negedge clk);
    pulse_sw;
    @(negedge clk);
    chk("R8 no capture while stopped", evt_cnt - base, 0);
    chk("R8 value kept", int'(cap_val), 6);
  endtask

  task automatic t_oneshot_ovf;
    start(1'b1, 1'b0, 1'b1, 2'b00);
    repeat (255) @(negedge clk);
    chk("R9 no flag before wrap", int'(ovf_flag), 0);
    chk("R8 running before wrap", int'(run_en), 1);
    @(negedge clk);
    chk("R9 flag on wrap", int'(ovf_flag), 1);
    chk("R8 one-shot disarm on wrap", int'(run_en), 0);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R9 flag cleared", int'(ovf_flag), 0);
  endtask

  task automatic t_cont_ovf;
    start(1'b0, 1'b0, 1'b1, 2'b00);
    repeat (258) @(negedge clk);
    chk("R7 still running after wrap", int'(run_en), 1);
    chk("R9 flag continuous", int'(ovf_flag), 1);
    pulse_sw;
    chk("R7 wrapped count", int'(cap_val), 2);
    write_run(1'b0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset cap_val", int'(cap_val), 0);
    chk("R11 reset cap_evt", int'(cap_evt), 0);
    chk("R9 reset ovf_flag", int'(ovf_flag), 0);
    chk("R1 reset run_en", int'(run_en), 0);
    t_sw_capture;
    t_sw_ignored;
    t_stop_resume;
    t_clear_on_cap;
    t_clr_with_cap;
    t_edges(2'b10, 2, 45, "R5 R6 rising");
    t_edges(2'b01, 2, 35, "R5 R6 falling");
    t_edges(2'b11, 4, 10, "R5 R6 both");
    t_edges(2'b00, 0, 0, "R5 none");
    t_oneshot_cap;
    t_oneshot_ovf;
    t_cont_ovf;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule